// File: doc/BRIEF.md
# SD Card Data Word FIFO with Debug Register

This block is the word buffer that sits between the host register port and the SD card data path. It holds up to 16 words of 32 bits. During a read transfer the card side fills it and software drains it through the data register. During a write transfer software fills it and the card side drains it. A direction input selects which pair of ports is active, so the ports of the other direction have no effect.

A single debug register packs four things together: the current fill level, a programmable read threshold, a programmable write threshold, and a 4-bit code for the data-path state. The state code is loaded by the serial data engine, which lies outside this block. Software can write a force bit that returns the reported state to the idle data-mode code. The block raises a data-available flag when enough words are present for a read, or enough space is free for a write. Any overflow or underflow sets a sticky FIFO error flag.

Top module: `sd_word_fifo`

## Requirements
- R1: After reset the fill level is 0, the state code is 0 (identification), both thresholds are 4, the FIFO error flag is 0 and pop_data is 0.
- R2: Words leave the FIFO in the order they were pushed. A popped word appears on pop_data on the cycle after the pop and holds there until the next pop.
- R3: Debug bits 8:4 report the fill level. It rises by one for each accepted push, falls by one for each accepted pop, and stays within 0 to 16.
- R4: A debug write with bit 19 clear loads the write threshold from bits 13:9 and the read threshold from bits 18:14. Both read back in the same positions.
- R5: Debug bits 3:0 report the data-path state code, which state_in loads when state_ld is high. Codes: 0 identification, 1 data mode, 2 read data, 3 write data, 4 read wait, 5 read CRC, 6 write CRC, 7 write wait 1, 8 power down, 9 power up, 10 write start 1, 11 write start 2, 12 pulse generation, 13 write wait 2, 15 power-down start.
- R6: A debug write with bit 19 set sets the state code to 1. This takes priority over state_ld. The write leaves both thresholds unchanged, and bit 19 always reads back 0.
- R7: When xfer_is_read is 1, data_avail is 1 exactly when the fill level is at least the read threshold.
- R8: When xfer_is_read is 0, data_avail is 1 exactly when the free space (16 minus fill) is at least the write threshold.
- R9: A push into a full FIFO without a same-cycle pop is dropped: the fill level stays 16 and the FIFO error flag sets.
- R10: A pop from an empty FIFO gives pop_data 0 on the next cycle and sets the FIFO error flag.
- R11: When xfer_is_read is 1, only card_push and reg_pop act. When it is 0, only reg_push and card_pop act. The two inactive port signals change neither the fill level nor pop_data.
- R12: The FIFO error flag stays set until err_clr is high. A new overflow or underflow in the clearing cycle keeps it set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| xfer_is_read | input | 1 | 1: card to host transfer, 0: host to card transfer |
| reg_push | input | 1 | Register-side push (write direction) |
| reg_pop | input | 1 | Register-side pop (read direction) |
| card_push | input | 1 | Card-side push (read direction) |
| card_pop | input | 1 | Card-side pop (write direction) |
| reg_wdata | input | 32 | Word pushed by the register side |
| card_wdata | input | 32 | Word pushed by the card side |
| pop_data | output | 32 | Word returned by the most recent pop |
| dbg_wr | input | 1 | Debug register write strobe |
| dbg_wdata | input | 20 | Debug register write value |
| dbg_rdata | output | 20 | Debug register read value |
| state_ld | input | 1 | Load strobe for the data-path state code |
| state_in | input | 4 | Data-path state code from the data engine |
| data_avail | output | 1 | Threshold reached for the current direction |
| fifo_err | output | 1 | Sticky overflow/underflow flag |
| err_clr | input | 1 | Clears the FIFO error flag |

## Verification
Fill level, thresholds, state code, the error flag and pop_data all come from registers, so each one reflects a stimulus one clock edge after that stimulus is driven. data_avail follows the registered fill and thresholds without delay, and it also follows xfer_is_read within the same cycle. The bench drives each input just after a falling edge and samples on the next falling edge, so exactly one rising edge lies between stimulus and check. For data_avail, the bench changes the direction between rising edges and samples after a short settle. The sweep covers every fill level from 0 to 16 against thresholds 0 to 17 in both directions, with expected values computed arithmetically.

// File: rtl/sdf_pkg.sv
package sdf_pkg;
  typedef enum logic [3:0] {
    ST_IDENT        = 4'd0,
    ST_DATA         = 4'd1,
    ST_RD_DATA      = 4'd2,
    ST_WR_DATA      = 4'd3,
    ST_RD_WAIT      = 4'd4,
    ST_RD_CRC       = 4'd5,
    ST_WR_CRC       = 4'd6,
    ST_WR_WAIT1     = 4'd7,
    ST_PWR_DN       = 4'd8,
    ST_PWR_UP       = 4'd9,
    ST_WR_START1    = 4'd10,
    ST_WR_START2    = 4'd11,
    ST_PULSES       = 4'd12,
    ST_WR_WAIT2     = 4'd13,
    ST_PWR_DN_START = 4'd15
  } dp_state_e;

  localparam int STATE_W = 4;
endpackage

// File: rtl/sdf_store.sv
module sdf_store #(
  parameter int W = 32,
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH),
  localparam int FW = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [W-1:0]  wdata,
  input  logic          pop,
  output logic [W-1:0]  rdata,
  output logic [FW-1:0] fill,
  output logic          ovf,
  output logic          unf
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [FW-1:0] fill_q;
  logic [W-1:0]  ram_q;
  logic          zero_q;
  logic          full, empty, push_ok, pop_ok;

  function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full    = (fill_q == FW'(DEPTH));
  assign empty   = (fill_q == '0);
  assign pop_ok  = pop && !empty;
  assign push_ok = push && (!full || pop_ok);
  assign ovf     = push && !push_ok;
  assign unf     = pop && !pop_ok;

  always_ff @(posedge clk) begin
    if (push_ok) mem[wptr] <= wdata;
    if (pop_ok)  ram_q <= mem[rptr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr   <= '0;
      rptr   <= '0;
      fill_q <= '0;
      zero_q <= 1'b1;
    end else begin
      if (push_ok) wptr <= ptr_next(wptr);
      if (pop_ok)  rptr <= ptr_next(rptr);
      fill_q <= fill_q + FW'(push_ok) - FW'(pop_ok);
      if (pop) zero_q <= !pop_ok;
    end
  end

  assign rdata = zero_q ? '0 : ram_q;
  assign fill  = fill_q;

  // R3
  fill_bound_chk: assert property (@(posedge clk) disable iff (rst)
    fill_q <= FW'(DEPTH));

  // R9
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    (full && push && !pop) |=> (fill_q == FW'(DEPTH)));

  // R10
  underflow_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (empty && pop) |=> (rdata == '0));
endmodule

// File: rtl/sdf_dbgreg.sv
module sdf_dbgreg #(
  parameter int DEPTH = 16,
  parameter int THR_RST = 4,
  localparam int FW = $clog2(DEPTH) + 1,
  localparam int SW = sdf_pkg::STATE_W,
  localparam int DW = SW + 3 * FW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          dbg_wr,
  input  logic [DW-1:0] dbg_wdata,
  input  logic          state_ld,
  input  logic [SW-1:0] state_in,
  input  logic [FW-1:0] fill,
  input  logic          xfer_is_read,
  output logic [DW-1:0] dbg_rdata,
  output logic          data_avail
);
  import sdf_pkg::*;

  localparam int FILL_LSB = SW;
  localparam int WTHR_LSB = SW + FW;
  localparam int RTHR_LSB = SW + 2 * FW;
  localparam int FORCE_B  = SW + 3 * FW;

  logic [SW-1:0] state_q;
  logic [FW-1:0] wthr_q, rthr_q;
  logic          force_wr;
  logic [FW-1:0] space;
  logic          unused_dbg_bits;

  assign force_wr = dbg_wr && dbg_wdata[FORCE_B];
  assign unused_dbg_bits = ^{dbg_wdata[WTHR_LSB-1:0]};

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDENT;
      wthr_q  <= FW'(THR_RST);
      rthr_q  <= FW'(THR_RST);
    end else begin
      if (force_wr)      state_q <= ST_DATA;
      else if (state_ld) state_q <= state_in;
      if (dbg_wr && !dbg_wdata[FORCE_B]) begin
        wthr_q <= dbg_wdata[WTHR_LSB +: FW];
        rthr_q <= dbg_wdata[RTHR_LSB +: FW];
      end
    end
  end

  assign space      = FW'(DEPTH) - fill;
  assign data_avail = xfer_is_read ? (fill >= rthr_q) : (space >= wthr_q);
  assign dbg_rdata  = {1'b0, rthr_q, wthr_q, fill, state_q};

  // R6
  force_state_chk: assert property (@(posedge clk) disable iff (rst)
    force_wr |=> (dbg_rdata[SW-1:0] == ST_DATA));

  // R4
  thr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!dbg_wr || force_wr) |=> ($stable(wthr_q) && $stable(rthr_q)));

  // R6
  force_reads_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !dbg_rdata[FORCE_B]);
endmodule

// File: rtl/sd_word_fifo.sv
module sd_word_fifo #(
  parameter int W = 32,
  parameter int DEPTH = 16,
  parameter int THR_RST = 4,
  localparam int FW = $clog2(DEPTH) + 1,
  localparam int DW = sdf_pkg::STATE_W + 3 * FW + 1
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        xfer_is_read,
  input  logic                        reg_push,
  input  logic                        reg_pop,
  input  logic                        card_push,
  input  logic                        card_pop,
  input  logic [W-1:0]                reg_wdata,
  input  logic [W-1:0]                card_wdata,
  output logic [W-1:0]                pop_data,
  input  logic                        dbg_wr,
  input  logic [DW-1:0]               dbg_wdata,
  output logic [DW-1:0]               dbg_rdata,
  input  logic                        state_ld,
  input  logic [sdf_pkg::STATE_W-1:0] state_in,
  output logic                        data_avail,
  output logic                        fifo_err,
  input  logic                        err_clr
);
  logic          push, pop, ovf, unf, err_q;
  logic [W-1:0]  wdata;
  logic [FW-1:0] fill;

  assign push  = xfer_is_read ? card_push : reg_push;
  assign pop   = xfer_is_read ? reg_pop   : card_pop;
  assign wdata = xfer_is_read ? card_wdata : reg_wdata;

  sdf_store #(.W(W), .DEPTH(DEPTH)) u_store (
    .clk(clk), .rst(rst), .push(push), .wdata(wdata), .pop(pop),
    .rdata(pop_data), .fill(fill), .ovf(ovf), .unf(unf)
  );

  sdf_dbgreg #(.DEPTH(DEPTH), .THR_RST(THR_RST)) u_dbg (
    .clk(clk), .rst(rst), .dbg_wr(dbg_wr), .dbg_wdata(dbg_wdata),
    .state_ld(state_ld), .state_in(state_in), .fill(fill),
    .xfer_is_read(xfer_is_read), .dbg_rdata(dbg_rdata),
    .data_avail(data_avail)
  );

  always_ff @(posedge clk) begin
    if (rst) err_q <= 1'b0;
    else     err_q <= (err_q && !err_clr) || ovf || unf;
  end
  assign fifo_err = err_q;

  // R12
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (fifo_err && !err_clr) |=> fifo_err);

  // R9
  ovf_err_chk: assert property (@(posedge clk) disable iff (rst)
    ovf |=> fifo_err);

  // R10
  unf_err_chk: assert property (@(posedge clk) disable iff (rst)
    unf |=> fifo_err);
endmodule

// File: tb/sim_sd_word_fifo.sv
module sim_sd_word_fifo;
  localparam int DEPTH = 16;
  logic clk = 0, rst = 1;
  logic xfer_is_read = 1, reg_push = 0, reg_pop = 0, card_push = 0, card_pop = 0;
  logic [31:0] reg_wdata = 0, card_wdata = 0, pop_data;
  logic dbg_wr = 0, state_ld = 0, data_avail, fifo_err, err_clr = 0;
  logic [19:0] dbg_wdata = 0, dbg_rdata;
  logic [3:0] state_in = 0;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  sd_word_fifo u0 (
    .clk(clk), .rst(rst), .xfer_is_read(xfer_is_read), .reg_push(reg_push),
    .reg_pop(reg_pop), .card_push(card_push), .card_pop(card_pop),
    .reg_wdata(reg_wdata), .card_wdata(card_wdata), .pop_data(pop_data),
    .dbg_wr(dbg_wr), .dbg_wdata(dbg_wdata), .dbg_rdata(dbg_rdata),
    .state_ld(state_ld), .state_in(state_in), .data_avail(data_avail),
    .fifo_err(fifo_err), .err_clr(err_clr)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1; cyc(); cyc(); rst = 0;
  endtask

  task automatic push_w(input logic [31:0] d);
    if (xfer_is_read) begin card_push = 1; card_wdata = d; end
    else begin reg_push = 1; reg_wdata = d; end
    cyc();
    card_push = 0; reg_push = 0;
  endtask

  task automatic pop_w();
    if (xfer_is_read) reg_pop = 1; else card_pop = 1;
    cyc();
    reg_pop = 0; card_pop = 0;
  endtask

  task automatic set_thr(input int rt, input int wt);
    dbg_wr = 1;
    dbg_wdata = {1'b0, 5'(rt), 5'(wt), 5'h0, 4'h0};
    cyc();
    dbg_wr = 0;
  endtask

  function automatic logic [31:0] pat(input int i, input int k);
    return 32'hA5000000 ^ (32'(i) * 32'h00010203) ^ (32'(k) << 20);
  endfunction

  initial begin
    @(negedge clk);
    do_reset();
    // R1 reset state
    chk(dbg_rdata[8:4] == 0, "R1 fill", 32'(dbg_rdata[8:4]), 0);
    chk(dbg_rdata[3:0] == 0, "R1 state", 32'(dbg_rdata[3:0]), 0);
    chk(dbg_rdata[13:9] == 4, "R1 wthr", 32'(dbg_rdata[13:9]), 4);
    chk(dbg_rdata[18:14] == 4, "R1 rthr", 32'(dbg_rdata[18:14]), 4);
    chk(fifo_err == 0, "R1 err", 32'(fifo_err), 0);
    chk(pop_data == 0, "R1 pop_data", pop_data, 0);

    // R3 R4 R7 R8 sweep of threshold against every fill level
    for (int t = 0; t < 18; t++) begin
      do_reset();
      set_thr(t, 17 - t);
      chk(dbg_rdata[18:14] == 5'(t), "R4 rthr", 32'(dbg_rdata[18:14]), 32'(t));
      chk(dbg_rdata[13:9] == 5'(17 - t), "R4 wthr", 32'(dbg_rdata[13:9]), 32'(17 - t));
      for (int n = 0; n <= DEPTH; n++) begin
        chk(dbg_rdata[8:4] == 5'(n), "R3 fill", 32'(dbg_rdata[8:4]), 32'(n));
        xfer_is_read = 1; #1;
        chk(data_avail == (n >= t), "R7 read avail", 32'(data_avail), 32'(n >= t));
        xfer_is_read = 0; #1;
        chk(data_avail == ((DEPTH - n) >= (17 - t)), "R8 write avail",
            32'(data_avail), 32'((DEPTH - n) >= (17 - t)));
        xfer_is_read = 1;
        if (n < DEPTH) push_w(pat(n, t));
      end
      chk(fifo_err == 0, "R9 no spurious err", 32'(fifo_err), 0);
    end

    // R2 R9 R10 R12 in both directions
    for (int dir = 1; dir >= 0; dir--) begin
      do_reset();
      xfer_is_read = dir[0];
      for (int i = 0; i < DEPTH; i++) push_w(pat(i, dir));
      push_w(32'hDEADBEEF);
      chk(dbg_rdata[8:4] == 16, "R9 full stays", 32'(dbg_rdata[8:4]), 16);
      chk(fifo_err == 1, "R9 overflow err", 32'(fifo_err), 1);
      err_clr = 1; cyc(); err_clr = 0;
      chk(fifo_err == 0, "R12 cleared", 32'(fifo_err), 0);
      for (int i = 0; i < DEPTH; i++) begin
        pop_w();
        chk(pop_data == pat(i, dir), "R2 order", pop_data, pat(i, dir));
      end
      cyc();
      chk(pop_data == pat(DEPTH - 1, dir), "R2 hold", pop_data, pat(DEPTH - 1, dir));
      pop_w();
      chk(pop_data == 0, "R10 empty pop zero", pop_data, 0);
      chk(fifo_err == 1, "R10 underflow err", 32'(fifo_err), 1);
      cyc(); cyc();
      chk(fifo_err == 1, "R12 sticky", 32'(fifo_err), 1);
      err_clr = 1;
      if (xfer_is_read) reg_pop = 1; else card_pop = 1;
      cyc();
      err_clr = 0; reg_pop = 0; card_pop = 0;
      chk(fifo_err == 1, "R12 set wins", 32'(fifo_err), 1);
    end

    // R11 inactive ports
    do_reset();
    xfer_is_read = 1;
    push_w(32'h11112222);
    pop_w();
    reg_push = 1; reg_wdata = 32'h5555; card_pop = 1; cyc(); reg_push = 0; card_pop = 0;
    chk(dbg_rdata[8:4] == 0, "R11 read dir fill", 32'(dbg_rdata[8:4]), 0);
    chk(pop_data == 32'h11112222, "R11 read dir data", pop_data, 32'h11112222);
    chk(fifo_err == 0, "R11 read dir err", 32'(fifo_err), 0);
    xfer_is_read = 0;
    push_w(32'h33334444);
    card_push = 1; card_wdata = 32'h7777; reg_pop = 1; cyc(); card_push = 0; reg_pop = 0;
    chk(dbg_rdata[8:4] == 1, "R11 write dir fill", 32'(dbg_rdata[8:4]), 1);
    chk(pop_data == 32'h11112222, "R11 write dir data", pop_data, 32'h11112222);
    pop_w();
    chk(pop_data == 32'h33334444, "R11 write dir word", pop_data, 32'h33334444);

    // R5 every state code
    for (int s = 0; s < 16; s++) begin
      state_ld = 1; state_in = 4'(s); cyc(); state_ld = 0;
      chk(dbg_rdata[3:0] == 4'(s), "R5 state load", 32'(dbg_rdata[3:0]), 32'(s));
    end

    // R6 force bit
    set_thr(9, 6);
    state_ld = 1; state_in = 4'd5; cyc(); state_ld = 0;
    dbg_wr = 1; dbg_wdata = 20'hFFFFF; state_ld = 1; state_in = 4'd12;
    cyc();
    dbg_wr = 0; state_ld = 0;
    chk(dbg_rdata[3:0] == 1, "R6 forced data", 32'(dbg_rdata[3:0]), 1);
    chk(dbg_rdata[18:14] == 9, "R6 rthr kept", 32'(dbg_rdata[18:14]), 9);
    chk(dbg_rdata[13:9] == 6, "R6 wthr kept", 32'(dbg_rdata[13:9]), 6);
    chk(dbg_rdata[19] == 0, "R6 reads zero", 32'(dbg_rdata[19]), 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule